// File: doc/BRIEF.md
# Dual-Plane Flash Status Bit Generator

This block forms the byte returned on a read from a flash-style memory model whose two planes can each be busy with an embedded program or erase. A command decoder outside the block reports program starts, erase starts, suspend, resume and completion. The block then decides, on every read strobe, whether the byte from the array goes out unchanged or whether data lines 7, 6 and 2 are replaced by progress status. The choice depends on the plane and the sector being read.

A read from a plane that is not busy always returns true array data. Software can therefore run code from one plane while the other is being written. Data line 6 toggles on successive reads of a busy plane. Data line 2 is a second toggle that points software at the sector whose erase is on hold. Data line 7 reports polarity: the inverse of the byte being programmed, or zero during an erase. The array, the analog timing and the command decoder are outside the block. It sees only decoded command codes, read strobes and the array byte for the read address.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both planes are idle, both toggle bits of each plane are 0, and rd_data_o is 0.
- R2: The plane is chosen by the two top address bits q: plane 0 when bit q of PLANE0_MAP is set, else plane 1. With the default map only q=0 is plane 0. A read of an idle plane returns rd_array_i unchanged, whatever the other plane is doing.
- R3: While a plane is programming, a read from it returns these bits: bit 7 is the inverse of bit 7 of the loaded byte when the read address equals the loaded address, and array bit 7 otherwise. Bit 6 is the plane's bit-6 toggle and bit 2 is 1. All other bits come from the array.
- R4: While a plane is erasing, a read from it returns bit 7 = 0, bit 6 = the bit-6 toggle and bit 2 = the bit-2 toggle. All other bits come from the array.
- R5: A toggle read returns the stored toggle value and then inverts it. A plane's toggle advances only on a read strobe whose output uses that toggle. It is held otherwise, including while the plane is idle.
- R6: Command 3 (suspend, no address) puts an erasing plane on hold. A read of the held sector (address bits from SECT_LSB upward equal) then returns bits 7 and 6 = 1 and bit 2 = the bit-2 toggle. Any other sector returns true data.
- R7: A program accepted on a held plane gives program-under-hold. Reads of the held sector behave as in R6. Other reads of that plane return bit 7 as in R3, bit 6 = the bit-6 toggle and bit 2 = the bit-2 toggle. Completion returns the plane to hold.
- R8: Command 4 (resume) addressed to a held plane returns it to erasing.
- R9: Command 5 (done) addressed to a programming or erasing plane makes it idle, and the next read returns true data.
- R10: Command 1 (program) is refused while any plane is programming or programming under hold, or while the target plane is erasing. Command 2 (erase) is refused unless the target plane is idle and no plane is erasing or on hold. Suspend does nothing while no plane is erasing. Command 0 is no operation.
- R11: rd_data_o is loaded at the clock edge where rd_i is high, from the state before that edge, and holds otherwise. A command at the same edge affects only later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code (0 none, 1 program, 2 erase, 3 suspend, 4 resume, 5 done) |
| cmd_addr_i | input | ADDR_W | Command address (program word, erase sector, plane for resume/done) |
| cmd_data_i | input | 8 | Byte loaded by a program command |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Read address |
| rd_array_i | input | 8 | Array byte at rd_addr_i |
| rd_data_o | output | 8 | Returned read byte |

## Verification
A wrong plane state shows at the ports on the first read of that plane. Status appears where true data was due, or the reverse, and the mismatch can be seen one cycle after the strobe. A toggle that advances when it should not, or fails to advance, can hide behind an equal value for one read. It is exposed by the second toggle read of the same plane, so the scenarios read each busy plane several times in a row and mix in reads of idle planes. Errors in the stored address, data or held sector show only when the read lands exactly on, or just beside, that address or sector, so both cases are read.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int unsigned NUM_PLANES = 2;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PROG      = 3'd1,
    ST_ERASE     = 3'd2,
    ST_SUSP      = 3'd3,
    ST_SUSP_PROG = 3'd4
  } plane_state_e;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_PROG    = 3'd1,
    CMD_ERASE   = 3'd2,
    CMD_SUSPEND = 3'd3,
    CMD_RESUME  = 3'd4,
    CMD_DONE    = 3'd5
  } cmd_e;

  function automatic logic plane_of(input logic [1:0] quarter, input logic [3:0] map);
    return map[quarter] ? 1'b0 : 1'b1;
  endfunction

  function automatic logic is_prog(input plane_state_e s);
    return (s == ST_PROG) || (s == ST_SUSP_PROG);
  endfunction

  function automatic logic is_erase(input plane_state_e s);
    return (s == ST_ERASE) || (s == ST_SUSP) || (s == ST_SUSP_PROG);
  endfunction

endpackage

// File: rtl/fsg_plane_ctrl.sv
module fsg_plane_ctrl
  import flash_status_pkg::*;
#(
  parameter logic PLANE_IDX = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cmd_e         cmd_i,
  input  logic         cmd_plane_i,
  input  logic         any_prog_i,
  input  logic         any_erase_i,
  input  logic         adv6_i,
  input  logic         adv2_i,
  output plane_state_e state_o,
  output logic         t6_o,
  output logic         t2_o,
  output logic         prog_acc_o,
  output logic         erase_acc_o
);

  plane_state_e state_q, state_d;
  logic t6_q, t2_q;
  logic hit;

  assign hit = (cmd_plane_i == PLANE_IDX);

  assign prog_acc_o  = (cmd_i == CMD_PROG) && hit && !any_prog_i &&
                       ((state_q == ST_IDLE) || (state_q == ST_SUSP));
  assign erase_acc_o = (cmd_i == CMD_ERASE) && hit && !any_erase_i &&
                       (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (prog_acc_o)       state_d = ST_PROG;
        else if (erase_acc_o) state_d = ST_ERASE;
      end
      ST_PROG: begin
        if (cmd_i == CMD_DONE && hit) state_d = ST_IDLE;
      end
      ST_ERASE: begin
        if (cmd_i == CMD_SUSPEND)          state_d = ST_SUSP;
        else if (cmd_i == CMD_DONE && hit) state_d = ST_IDLE;
      end
      ST_SUSP: begin
        if (prog_acc_o)                      state_d = ST_SUSP_PROG;
        else if (cmd_i == CMD_RESUME && hit) state_d = ST_ERASE;
      end
      ST_SUSP_PROG: begin
        if (cmd_i == CMD_DONE && hit) state_d = ST_SUSP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      t6_q    <= 1'b0;
      t2_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (adv6_i) t6_q <= ~t6_q;
      if (adv2_i) t2_q <= ~t2_q;
    end
  end

  assign state_o = state_q;
  assign t6_o    = t6_q;
  assign t2_o    = t2_q;

  // toggles frozen while idle (R5)
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> $stable({t6_q, t2_q}));

  // a programming plane never drives the bit-2 toggle (R3)
  a_r3_prog_no_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG) |=> $stable(t2_q));

  a_r8_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && cmd_i == CMD_RESUME && hit) |=> (state_q == ST_ERASE));

endmodule

// File: rtl/fsg_op_regs.sv
module fsg_op_regs #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SECT_LSB = 15,
  localparam int unsigned SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_acc_i,
  input  logic              erase_acc_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_data_i,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic              last_d7_o,
  output logic [SECT_W-1:0] erase_sect_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_o  <= '0;
      last_d7_o    <= 1'b0;
      erase_sect_o <= '0;
    end else begin
      if (prog_acc_i) begin
        last_addr_o <= cmd_addr_i;
        last_d7_o   <= cmd_data_i[7];
      end
      if (erase_acc_i) erase_sect_o <= cmd_addr_i[ADDR_W-1:SECT_LSB];
    end
  end

endmodule

// File: rtl/fsg_read_mux.sv
module fsg_read_mux
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned SECT_LSB   = 15,
  parameter logic [3:0]  PLANE0_MAP = 4'b0001,
  localparam int unsigned SECT_W    = ADDR_W - SECT_LSB
) (
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [7:0]             rd_array_i,
  input  plane_state_e           state_i [NUM_PLANES],
  input  logic [NUM_PLANES-1:0]  t6_i,
  input  logic [NUM_PLANES-1:0]  t2_i,
  input  logic [ADDR_W-1:0]      last_addr_i,
  input  logic                   last_d7_i,
  input  logic [SECT_W-1:0]      erase_sect_i,
  output logic [7:0]             value_o,
  output logic [NUM_PLANES-1:0]  use6_o,
  output logic [NUM_PLANES-1:0]  use2_o
);

  logic         pl;
  logic         sect_hit;
  logic         last_hit;
  logic         poll7;
  plane_state_e st;

  assign pl       = plane_of(rd_addr_i[ADDR_W-1 -: 2], PLANE0_MAP);
  assign st       = state_i[pl];
  assign sect_hit = (rd_addr_i[ADDR_W-1:SECT_LSB] == erase_sect_i);
  assign last_hit = (rd_addr_i == last_addr_i);
  assign poll7    = last_hit ? ~last_d7_i : rd_array_i[7];

  always_comb begin
    value_o = rd_array_i;
    use6_o  = '0;
    use2_o  = '0;
    unique case (st)
      ST_PROG: begin
        value_o[7] = poll7;
        value_o[6] = t6_i[pl];
        value_o[2] = 1'b1;
        use6_o[pl] = 1'b1;
      end
      ST_ERASE: begin
        value_o[7] = 1'b0;
        value_o[6] = t6_i[pl];
        value_o[2] = t2_i[pl];
        use6_o[pl] = 1'b1;
        use2_o[pl] = 1'b1;
      end
      ST_SUSP, ST_SUSP_PROG: begin
        if (sect_hit) begin
          value_o[7] = 1'b1;
          value_o[6] = 1'b1;
          value_o[2] = t2_i[pl];
          use2_o[pl] = 1'b1;
        end else if (st == ST_SUSP_PROG) begin
          value_o[7] = poll7;
          value_o[6] = t6_i[pl];
          value_o[2] = t2_i[pl];
          use6_o[pl] = 1'b1;
          use2_o[pl] = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned SECT_LSB   = 15,
  parameter logic [3:0]  PLANE0_MAP = 4'b0001,
  localparam int unsigned SECT_W    = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        rd_array_i,
  output logic [7:0]        rd_data_o
);

  cmd_e                  cmd;
  logic                  cmd_plane;
  plane_state_e          state [NUM_PLANES];
  logic [NUM_PLANES-1:0] t6, t2, use6, use2, prog_acc, erase_acc, busy_prog, busy_erase;
  logic                  any_prog, any_erase;
  logic [ADDR_W-1:0]     last_addr;
  logic                  last_d7;
  logic [SECT_W-1:0]     erase_sect;
  logic [7:0]            value;

  assign cmd       = cmd_e'(cmd_i);
  assign cmd_plane = plane_of(cmd_addr_i[ADDR_W-1 -: 2], PLANE0_MAP);
  assign any_prog  = |busy_prog;
  assign any_erase = |busy_erase;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    assign busy_prog[p]  = is_prog(state[p]);
    assign busy_erase[p] = is_erase(state[p]);

    fsg_plane_ctrl #(.PLANE_IDX(1'(p))) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (cmd),
      .cmd_plane_i (cmd_plane),
      .any_prog_i  (any_prog),
      .any_erase_i (any_erase),
      .adv6_i      (rd_i & use6[p]),
      .adv2_i      (rd_i & use2[p]),
      .state_o     (state[p]),
      .t6_o        (t6[p]),
      .t2_o        (t2[p]),
      .prog_acc_o  (prog_acc[p]),
      .erase_acc_o (erase_acc[p])
    );
  end

  fsg_op_regs #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_acc_i   (|prog_acc),
    .erase_acc_i  (|erase_acc),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_data_i   (cmd_data_i),
    .last_addr_o  (last_addr),
    .last_d7_o    (last_d7),
    .erase_sect_o (erase_sect)
  );

  fsg_read_mux #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .PLANE0_MAP(PLANE0_MAP)) u_mux (
    .rd_addr_i    (rd_addr_i),
    .rd_array_i   (rd_array_i),
    .state_i      (state),
    .t6_i         (t6),
    .t2_i         (t2),
    .last_addr_i  (last_addr),
    .last_d7_i    (last_d7),
    .erase_sect_i (erase_sect),
    .value_o      (value),
    .use6_o       (use6),
    .use2_o       (use2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= value;
  end

  logic         rd_pl;
  plane_state_e rd_st;
  assign rd_pl = plane_of(rd_addr_i[ADDR_W-1 -: 2], PLANE0_MAP);
  assign rd_st = state[rd_pl];

  a_r2_idle_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_st == ST_IDLE) |=> (rd_data_o == $past(rd_array_i)));

  a_r4_erase_b7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_st == ST_ERASE) |=> (rd_data_o[7] == 1'b0));

  a_r3_prog_b2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_st == ST_PROG) |=> rd_data_o[2]);

  a_r6_held_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (rd_st == ST_SUSP || rd_st == ST_SUSP_PROG) &&
     rd_addr_i[ADDR_W-1:SECT_LSB] == erase_sect) |=> (rd_data_o[7:6] == 2'b11));

  a_r10_single_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy_prog) <= 1);

  a_r10_single_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy_erase) <= 1);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));

endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [19:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        rd = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [7:0]  rd_array;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] arr_of(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign rd_array = arr_of(rd_addr);

  flash_status_gen u_flash_status_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmd_i      (cmd),
    .cmd_addr_i (cmd_addr),
    .cmd_data_i (cmd_data),
    .rd_i       (rd),
    .rd_addr_i  (rd_addr),
    .rd_array_i (rd_array),
    .rd_data_o  (rd_data)
  );

  // reference model: 0 idle, 1 program, 2 erase, 3 held, 4 program under hold
  int          m_st [2];
  bit          m_t6 [2];
  bit          m_t2 [2];
  logic [19:0] m_la;
  bit          m_l7;
  logic [4:0]  m_es;
  logic [7:0]  m_exp;

  function automatic int pl_of(input logic [19:0] a);
    return (a[19:18] == 2'd0) ? 0 : 1;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin m_st[p] = 0; m_t6[p] = 0; m_t2[p] = 0; end
    m_la = '0; m_l7 = 0; m_es = '0; m_exp = 8'h00;
  endtask

  task automatic model_step(input int c, input logic [19:0] ca, input logic [7:0] cd,
                            input bit r, input logic [19:0] ra);
    int p, q;
    bit ap, ae;
    logic [7:0] e;
    if (r) begin
      p = pl_of(ra);
      e = arr_of(ra);
      if (m_st[p] == 1) begin
        if (ra == m_la) e[7] = ~m_l7;
        e[6] = m_t6[p]; m_t6[p] = ~m_t6[p];
        e[2] = 1'b1;
      end else if (m_st[p] == 2) begin
        e[7] = 1'b0;
        e[6] = m_t6[p]; m_t6[p] = ~m_t6[p];
        e[2] = m_t2[p]; m_t2[p] = ~m_t2[p];
      end else if (m_st[p] >= 3 && ra[19:15] == m_es) begin
        e[7] = 1'b1; e[6] = 1'b1;
        e[2] = m_t2[p]; m_t2[p] = ~m_t2[p];
      end else if (m_st[p] == 4) begin
        if (ra == m_la) e[7] = ~m_l7;
        e[6] = m_t6[p]; m_t6[p] = ~m_t6[p];
        e[2] = m_t2[p]; m_t2[p] = ~m_t2[p];
      end
      m_exp = e;
    end
    ap = (m_st[0] == 1 || m_st[0] == 4 || m_st[1] == 1 || m_st[1] == 4);
    ae = (m_st[0] >= 2 || m_st[1] >= 2);
    q = pl_of(ca);
    case (c)
      1: if (!ap && (m_st[q] == 0 || m_st[q] == 3)) begin
           m_st[q] = (m_st[q] == 0) ? 1 : 4; m_la = ca; m_l7 = cd[7];
         end
      2: if (!ae && m_st[q] == 0) begin m_st[q] = 2; m_es = ca[19:15]; end
      3: for (int k = 0; k < 2; k++) if (m_st[k] == 2) m_st[k] = 3;
      4: if (m_st[q] == 3) m_st[q] = 2;
      5: begin
           if (m_st[q] == 1 || m_st[q] == 2) m_st[q] = 0;
           else if (m_st[q] == 4) m_st[q] = 3;
         end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag);
    checks++;
    if (rd_data !== m_exp) begin
      fails++;
      $display("FAIL %s: rd_data_o=%h expected=%h at %0t", tag, rd_data, m_exp, $time);
    end
  endtask

  // one clock: drive, edge, model, compare at the falling edge
  task automatic cyc(input int c, input logic [19:0] ca, input logic [7:0] cd,
                     input bit r, input logic [19:0] ra, input string tag);
    cmd = 3'(c); cmd_addr = ca; cmd_data = cd; rd = r; rd_addr = ra;
    @(posedge clk);
    #1 model_step(c, ca, cd, r, ra);
    @(negedge clk);
    compare(tag);
    cmd = 3'd0; rd = 1'b0;
  endtask

  task automatic rdc(input logic [19:0] ra, input string tag);
    cyc(0, '0, 8'h00, 1'b1, ra, tag);
  endtask

  task automatic cmdc(input int c, input logic [19:0] ca, input logic [7:0] cd, input string tag);
    cyc(c, ca, cd, 1'b0, '0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  localparam logic [19:0] PA = 20'h4_8010;  // plane 1
  localparam logic [19:0] QA = 20'hC_0002;  // plane 1, other sector
  localparam logic [19:0] EA = 20'h0_9000;  // plane 0, erase sector
  localparam logic [19:0] EB = 20'h0_9A55;  // plane 0, same sector
  localparam logic [19:0] OA = 20'h0_1000;  // plane 0, other sector

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    rdc(EA, "R1 idle plane0 read");
    rdc(PA, "R1 R2 idle plane1 read");

    // program in plane 1, loaded bit 7 = 1
    cmdc(1, PA, 8'hA5, "R3 program start");
    for (int i = 0; i < 3; i++) rdc(PA, "R3 R5 poll last address");
    rdc(QA, "R3 other address same plane");
    rdc(OA, "R2 idle plane during program");
    rdc(20'h8_0000, "R2 quarter 2 maps to plane 1");
    cmdc(1, OA, 8'h00, "R10 second program refused");
    rdc(OA, "R10 plane0 stays idle");
    cmdc(2, QA, 8'h00, "R10 erase on programming plane refused");
    rdc(PA, "R3 R5 poll after refusals");
    cyc(5, PA, 8'h00, 1'b1, PA, "R11 done and read same edge");
    rdc(PA, "R9 true data after done");
    cmdc(3, '0, 8'h00, "R10 suspend with nothing erasing");
    rdc(PA, "R10 suspend ignored");

    // program with loaded bit 7 = 0 in plane 0
    cmdc(1, OA, 8'h12, "R3 program bit7 zero");
    rdc(OA, "R3 complement of zero");
    rdc(OA, "R3 R5 toggle second read");
    cmdc(5, OA, 8'h00, "R9 done plane0");
    rdc(OA, "R9 true data plane0");

    // erase in plane 0
    cmdc(2, EA, 8'h00, "R4 erase start");
    for (int i = 0; i < 3; i++) rdc(EB, "R4 R5 erase status");
    rdc(PA, "R2 idle plane1 during erase");
    cmdc(2, QA, 8'h00, "R10 second erase refused");
    rdc(QA, "R10 plane1 stays idle");
    cmdc(3, '0, 8'h00, "R6 suspend");
    for (int i = 0; i < 3; i++) rdc(EB, "R6 held sector");
    rdc(OA, "R6 other sector true data");
    cmdc(1, OA, 8'h80, "R7 program under hold");
    rdc(OA, "R7 poll under hold");
    rdc(OA, "R7 R5 poll under hold again");
    rdc(20'h0_1234, "R7 other address under hold");
    rdc(EA, "R7 held sector under program");
    rdc(PA, "R2 plane1 idle under hold");
    cmdc(5, OA, 8'h00, "R7 done back to hold");
    rdc(OA, "R7 true data after program");
    rdc(EA, "R6 held sector again");
    cmdc(4, EA, 8'h00, "R8 resume");
    rdc(EB, "R8 erase status after resume");
    rdc(EB, "R8 R5 erase toggle");
    cmdc(5, EA, 8'h00, "R9 erase done");
    rdc(EB, "R9 true data after erase");
    rdc(EB, "R5 R9 idle read held toggles");

    // program plane 1, then erase plane 0 concurrently; toggles resume from held values
    cmdc(1, PA, 8'h7F, "R3 program plane1 again");
    cmdc(2, EA, 8'h00, "R10 erase in other plane during program");
    rdc(PA, "R5 plane1 toggle resumes");
    rdc(EA, "R4 plane0 erase concurrent");
    rdc(PA, "R3 plane1 second poll");
    cmdc(5, PA, 8'h00, "R9 done plane1");
    cmdc(5, EA, 8'h00, "R9 done plane0");
    rdc(PA, "R9 final plane1");
    rdc(EA, "R9 final plane0");
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    compare("R1 reset mid-run");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule